// File: doc/BRIEF.md
# Matrix Coefficient Q3.12 Converter

This block turns colour-transform matrix coefficients into values that a 15-bit coefficient register can hold. Each input word is 64 bits wide and uses sign-magnitude fixed point. The top bit is the sign and the remaining bits are a magnitude with 32 integer and 32 fractional bits. Each output word is a 15-bit two's-complement number with 3 integer bits and 12 fractional bits (Q3.12). When the result cannot stand for the input's sign, the block raises a range flag.

Coefficients arrive as a stream, one per cycle in which `in_valid` is high. Nine accepted coefficients form one 3×3 matrix. Each converted word leaves one cycle later. It carries its own range flag and a marker on the ninth word of the group. The block also keeps a group error status that gathers every range flag seen in the current matrix.

The range check is made after negation. Because of that, the most negative Q3.12 value, -4.0, is accepted.

Top module: `mtx_coef_cvt`

## Requirements
- R1: For an input with bit 63 clear, `out_coef` equals input bits 34:20. Input bits 19:0 are dropped (truncation toward zero). Magnitude bits 62:35 are dropped.
- R2: For an input with bit 63 set, `out_coef` is the 15-bit two's complement of input bits 34:20, taken modulo 2^15.
- R3: `out_ovf` is 1 when the input sign (bit 63) differs from bit 14 of `out_coef`, unless input bits 34:20 are all zero. Whenever `out_ovf` is 0 and `out_coef` is nonzero, bit 14 of `out_coef` equals the input sign.
- R4: A negative input whose field (bits 34:20) is 0x4000, meaning -4.0, gives `out_coef` = 0x4000 with `out_ovf` = 0. A positive input with the same field gives `out_coef` = 0x4000 with `out_ovf` = 1.
- R5: An input whose field (bits 34:20) is zero gives `out_coef` = 0 and `out_ovf` = 0, whatever its sign. This covers negative zero.
- R6: `out_valid` is `in_valid` delayed by exactly one clock cycle. The word, flag and marker it qualifies come from the input of that earlier cycle.
- R7: Accepted inputs are numbered 0 to 8 within a group. Only cycles with `in_valid` high advance the count. `out_last` is 1 exactly on the output of position 8 and is 0 whenever `out_valid` is 0.
- R8: On each valid output, `grp_err` is the OR of `out_ovf` over that output and every earlier output of the same group. At position 0 it takes that word's flag alone, so the previous group's status is cleared. While `out_valid` is 0, `grp_err` keeps its value.
- R9: While `rst_n` is low, `out_valid`, `out_last` and `grp_err` are 0. The first input accepted after reset is position 0 of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A coefficient is presented this cycle |
| in_coef | input | 64 | Sign-magnitude coefficient, sign in bit 63, 32 fractional bits |
| out_valid | output | 1 | Converted word is present this cycle |
| out_coef | output | 15 | Two's-complement Q3.12 coefficient |
| out_ovf | output | 1 | Range error for this word |
| out_last | output | 1 | This word is position 8 of its group |
| grp_err | output | 1 | Any range error so far in the current group |

## Verification
The hardest situation to reach is the edge of the signed range. In that region a sign, a field of 0x4000 and an all-zero field each decide the flag differently. Uniform 64-bit words almost never produce an all-zero field or exactly 0x4000. The stimulus therefore mixes fully random words with words built around those field values under both signs. It also inserts idle cycles in the middle of groups. That last part checks that the group status survives gaps and clears only when the next group's first word arrives.

// File: rtl/mtx_coef_pkg.sv
package mtx_coef_pkg;
    // Default formats of the incoming and outgoing coefficients.
    localparam int CM_IN_W     = 64;
    localparam int CM_IN_FRAC  = 32;
    localparam int CM_OUT_W    = 15;
    localparam int CM_OUT_FRAC = 12;
    // Number of coefficients in one matrix.
    localparam int CM_GRP_N    = 9;
endpackage

// File: rtl/coef_field_cvt.sv
// Combinational datapath: take the field out of the magnitude, negate it when the
// sign is set, then decide the range error on the negated result.
module coef_field_cvt #(
    parameter int IN_W     = 64,
    parameter int IN_FRAC  = 32,
    parameter int OUT_W    = 15,
    parameter int OUT_FRAC = 12
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] val,
    output logic             ovf
);
    localparam int SHIFT = IN_FRAC - OUT_FRAC;
    localparam int HI    = SHIFT + OUT_W - 1;

    logic             sgn;
    logic [OUT_W-1:0] field;
    logic [OUT_W-1:0] neg;

    always_comb begin
        sgn   = raw[IN_W-1];
        field = raw[HI:SHIFT];
        neg   = ~field + {{(OUT_W-1){1'b0}}, 1'b1};
        val   = sgn ? neg : field;
        // A zero field never raises the flag, so negative zero passes.
        ovf   = (sgn != val[OUT_W-1]) && (field != '0);
    end
endmodule

// File: rtl/grp_pos.sv
// Position of the next accepted coefficient within its group.
module grp_pos #(
    parameter int GRP_N = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic first,
    output logic last
);
    localparam int CNT_W = (GRP_N > 1) ? $clog2(GRP_N) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GRP_N - 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        first = (cnt_q == '0);
        last  = (cnt_q == LAST_POS);
        cnt_d = cnt_q;
        if (adv) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mtx_coef_cvt.sv
module mtx_coef_cvt
    import mtx_coef_pkg::*;
#(
    parameter int IN_W     = CM_IN_W,
    parameter int IN_FRAC  = CM_IN_FRAC,
    parameter int OUT_W    = CM_OUT_W,
    parameter int OUT_FRAC = CM_OUT_FRAC,
    parameter int GRP_N    = CM_GRP_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_coef,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_coef,
    output logic             out_ovf,
    output logic             out_last,
    output logic             grp_err
);
    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] coef;
        logic             ovf;
        logic             last;
        logic             err;
    } out_st_t;

    out_st_t          st_d;
    out_st_t          st_q;
    logic [OUT_W-1:0] c_val;
    logic             c_ovf;
    logic             pos_first;
    logic             pos_last;

    coef_field_cvt #(
        .IN_W    (IN_W),
        .IN_FRAC (IN_FRAC),
        .OUT_W   (OUT_W),
        .OUT_FRAC(OUT_FRAC)
    ) u_cvt (
        .raw(in_coef),
        .val(c_val),
        .ovf(c_ovf)
    );

    grp_pos #(
        .GRP_N(GRP_N)
    ) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (in_valid),
        .first(pos_first),
        .last (pos_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.last = 1'b0;
        if (in_valid) begin
            st_d.coef = c_val;
            st_d.ovf  = c_ovf;
            st_d.last = pos_last;
            // Group status restarts on the first word of each matrix.
            st_d.err  = pos_first ? c_ovf : (st_q.err | c_ovf);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_coef  = st_q.coef;
    assign out_ovf   = st_q.ovf;
    assign out_last  = st_q.last;
    assign grp_err   = st_q.err;
endmodule

// File: rtl/mtx_coef_cvt_chk.sv
module mtx_coef_cvt_chk #(
    parameter int IN_W     = 64,
    parameter int IN_FRAC  = 32,
    parameter int OUT_W    = 15,
    parameter int OUT_FRAC = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_coef,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_coef,
    input logic             out_ovf,
    input logic             out_last,
    input logic             grp_err
);
    localparam int SHIFT = IN_FRAC - OUT_FRAC;
    localparam int HI    = SHIFT + OUT_W - 1;

    assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_zero_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_coef[HI:SHIFT] == '0)) |=> (out_coef == '0 && !out_ovf));

    assert_sign_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ovf && out_coef != '0) |-> (out_coef[OUT_W-1] == $past(in_coef[IN_W-1])));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> grp_err);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(grp_err));

    assert_last_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind mtx_coef_cvt mtx_coef_cvt_chk #(
    .IN_W    (IN_W),
    .IN_FRAC (IN_FRAC),
    .OUT_W   (OUT_W),
    .OUT_FRAC(OUT_FRAC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_coef  (in_coef),
    .out_valid(out_valid),
    .out_coef (out_coef),
    .out_ovf  (out_ovf),
    .out_last (out_last),
    .grp_err  (grp_err)
);

// File: tb/test_mtx_coef_cvt.sv
module test_mtx_coef_cvt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_coef = '0;
    logic        out_valid;
    logic [14:0] out_coef;
    logic        out_ovf;
    logic        out_last;
    logic        grp_err;

    always #5 clk = ~clk;

    mtx_coef_cvt i_mtx_coef_cvt (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_coef  (in_coef),
        .out_valid(out_valid),
        .out_coef (out_coef),
        .out_ovf  (out_ovf),
        .out_last (out_last),
        .grp_err  (grp_err)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    m_cnt = 0;
    logic  m_err = 1'b0;
    logic        e_vld  = 1'b0;
    logic [14:0] e_coef = '0;
    logic        e_ovf  = 1'b0;
    logic        e_last = 1'b0;
    logic        e_err  = 1'b0;
    string       e_tag  = "R9";

    // Expected word: R1 for positive inputs, R2 for negative ones.
    function automatic logic [14:0] ref_val(input logic [63:0] c);
        logic [14:0] f;
        f = c[34:20];
        return c[63] ? (15'(0) - f) : f;
    endfunction

    // Expected flag per R3, R5.
    function automatic logic ref_ovf(input logic [63:0] c);
        logic [14:0] v;
        v = ref_val(c);
        return (c[63] != v[14]) && (c[34:20] != 15'd0);
    endfunction

    task automatic check_out();
        bit bad;
        bad = 1'b0;
        n_vec++;
        if (out_valid !== e_vld) begin
            bad = 1'b1;
            $display("FAIL R6 out_valid act %b exp %b", out_valid, e_vld);
        end
        if (out_last !== e_last) begin
            bad = 1'b1;
            $display("FAIL R7 out_last act %b exp %b", out_last, e_last);
        end
        if (grp_err !== e_err) begin
            bad = 1'b1;
            $display("FAIL R8 grp_err act %b exp %b", grp_err, e_err);
        end
        if (e_vld) begin
            if (out_coef !== e_coef) begin
                bad = 1'b1;
                $display("FAIL %s out_coef act %h exp %h", e_tag, out_coef, e_coef);
            end
            if (out_ovf !== e_ovf) begin
                bad = 1'b1;
                $display("FAIL %s out_ovf act %b exp %b", e_tag, out_ovf, e_ovf);
            end
        end
        if (bad) n_bad++;
    endtask

    // Check the result of the previous beat, then present a new one.
    task automatic drive(input logic v, input logic [63:0] c, input string tag);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_coef  = c;
        e_vld    = v;
        e_last   = 1'b0;
        e_tag    = tag;
        if (v) begin
            e_coef = ref_val(c);
            e_ovf  = ref_ovf(c);
            e_last = (m_cnt == 8);
            e_err  = (m_cnt == 0) ? e_ovf : (m_err | e_ovf);
            m_err  = e_err;
            m_cnt  = (m_cnt == 8) ? 0 : m_cnt + 1;
        end
    endtask

    function automatic logic [63:0] rand_coef();
        logic [63:0] c;
        int unsigned sel;
        c   = {$urandom, $urandom};
        sel = $urandom % 8;
        if (sel == 0) c[34:20] = 15'h4000;
        else if (sel == 1) c[34:20] = 15'h0000;
        else if (sel == 2) c[62:35] = '0;
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd20240611);
        // R9: reset state
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if (out_valid !== 1'b0 || out_last !== 1'b0 || grp_err !== 1'b0) begin
                n_bad++;
                $display("FAIL R9 reset act vld=%b last=%b err=%b exp 0 0 0",
                         out_valid, out_last, grp_err);
            end
        end
        rst_n = 1'b1;
        // Directed group 1 with an idle gap inside it.
        drive(1'b1, 64'h0000_0001_0000_0000, "R1");   // +1.0 -> 0x1000
        drive(1'b1, 64'h8000_0001_0000_0000, "R2");   // -1.0 -> 0x7000
        drive(1'b1, 64'h8000_0004_0000_0000, "R4");   // -4.0 accepted
        drive(1'b0, 64'h0, "R6");
        drive(1'b1, 64'h8000_0000_0000_0000, "R5");   // negative zero
        drive(1'b1, 64'h8000_0000_000F_FFFF, "R5");   // truncates to zero
        drive(1'b1, 64'h0000_0008_0000_0000, "R1");   // above field, dropped
        drive(1'b1, 64'h0000_0003_FFF0_0000, "R1");   // largest positive 0x3FFF
        drive(1'b1, 64'h8000_0000_0010_0000, "R2");   // smallest negative step
        drive(1'b1, 64'h0000_0002_0000_0000, "R1");   // +2.0, position 8
        // Group 2: overflow in the middle, idle cycles, status held.
        drive(1'b1, 64'h0000_0001_8000_0000, "R1");
        drive(1'b1, 64'h0000_0004_0000_0000, "R4");   // +4.0 flagged
        drive(1'b0, 64'h0, "R8");
        drive(1'b0, 64'h0, "R8");
        for (int i = 0; i < 7; i++) drive(1'b1, 64'h0000_0000_4000_0000, "R7");
        // Group 3 starts clean: status cleared at position 0.
        drive(1'b1, 64'h8000_0002_0000_0000, "R8");
        drive(1'b1, 64'h8000_0006_0000_0000, "R3");   // negative, bit14 clear -> flag
        for (int i = 0; i < 7; i++) drive(1'b1, 64'h0, "R7");
        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [63:0] c;
            v = (($urandom % 4) != 0);
            c = rand_coef();
            drive(v, c, c[63] ? "R2" : "R1");
        end
        drive(1'b0, 64'h0, "R6");
        drive(1'b0, 64'h0, "R6");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule